// File: doc/BRIEF.md
# Precise Exception Entry Controller

This block commits a precise exception for a small 32-bit RISC core that has one branch delay slot. The pipeline raises a one-cycle request with the kind of exception, the faulting PC, the sequential next PC, the faulting virtual address and a coprocessor number. On the next clock edge the block updates its privileged state. The Status exception-level bit is set. The Cause code, delay-slot and coprocessor fields are written. The exception PC is recorded, and the bad-address register is loaded when the kind uses it. The shadow register set selectors are swapped when the entry conditions allow it. At the same edge the block puts the handler address, handler+4 and handler+8 on its PC outputs and raises a one-cycle redirect pulse.

The handler address depends on the kind of exception and on the pre-entry values of the exception-level, boot-vector and interrupt-vector bits. A software port can write and read all six privileged registers. The request has no back-pressure: the block accepts every request, one per cycle, and it has no ready signal. The software port, the PC outputs and the redirect pulse are plain control pins.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, pc_out is 0xBFC00000, npc_out is 0xBFC00004 and nnpc_out is 0xBFC00008, with redirect low. Status reads 0x20000000 (bit 29 is floating-point usable) and EBase reads 0x80000000. Cause, EPC, BadVAddr and the shadow control register read 0.
- R2: exc_kind uses this encoding: 0 TLB modified, 1 TLB load/fetch, 2 TLB store, 3 TLB refill load, 4 TLB refill store, 5 address error load, 6 address error store, 7 syscall, 8 breakpoint, 9 reserved instruction, 10 coprocessor unusable, 11 overflow, 12 trap, 13 interrupt. Kinds 14 and 15 act as reserved instruction. Entry writes Cause bits 6:2 with the code: 1, 2, 3, 2, 3, 4, 5, 8, 9, 0xA, 0xB, 0xC, 0xD, 0xA in that kind order. All other Cause bits outside 31 and 29:28 are kept.
- R3: If exc_npc differs from exc_pc+4, entry writes exc_pc-4 to EPC and sets Cause bit 31. Otherwise entry writes exc_pc to EPC and clears Cause bit 31.
- R4: Every entry sets Status bit 1 (exception level), even when it is already 1. No other Status bit changes.
- R5: The shadow control register has three fields: current set in bits 3:0, previous set in bits 9:6 and exception set in bits 15:12. When Status bit 1 and Status bit 22 (boot vector) are both 0 before entry, the previous set takes the old current set and the current set takes the exception set. Otherwise the register is unchanged. shadow_set always shows the current-set field.
- R6: Entry clears Cause bits 29:28. For coprocessor unusable (kind 10), entry loads those bits with exc_cpnum instead.
- R7: Most kinds vector to EBase+0x180. A TLB refill (kind 3 or 4) vectors to EBase+0 when Status bit 1 was 0 before entry, and to EBase+0x180 when it was 1.
- R8: An interrupt (kind 13) vectors to EBase+0x200 when Cause bit 23 is 1, and to EBase+0x180 when it is 0.
- R9: An overflow (kind 11) vectors to 0xBFC00200 when Status bit 22 is 1, and to EBase+0x180 when it is 0.
- R10: The edge that accepts a request loads pc_out with the handler address, npc_out with handler+4 and nnpc_out with handler+8. redirect is high for exactly the following cycle.
- R11: Kinds 0 to 6 load BadVAddr with exc_badva. All other kinds leave BadVAddr unchanged.
- R12: The software port addresses Status 0, Cause 1, EPC 2, BadVAddr 3, shadow control 4 and EBase 5. Addresses 6 and 7 read 0 and ignore writes. A write takes effect at the next edge, and reads are combinational. If the same edge also accepts an exception, the write is dropped for every register that the exception updates and still applies to the others. The vector always uses the EBase value from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | One-cycle exception request, always accepted |
| exc_kind | input | 4 | Exception kind (encoding in R2) |
| exc_pc | input | 32 | Faulting PC |
| exc_npc | input | 32 | Sequential next PC at the fault |
| exc_badva | input | 32 | Faulting virtual address |
| exc_cpnum | input | 2 | Coprocessor number for coprocessor-unusable |
| sw_we | input | 1 | Software register write enable |
| sw_addr | input | 3 | Software register select |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data (combinational) |
| pc_out | output | 32 | Core PC |
| npc_out | output | 32 | Core next PC |
| nnpc_out | output | 32 | Core next-next PC |
| redirect | output | 1 | One-cycle pulse after an entry |
| shadow_set | output | 4 | Active shadow register set |

## Verification
The bench builds the block with its default parameters. The instruction step is 4, so the delay-slot test in R3 can be reached with ordinary PC pairs. The reset PC, the reset EBase and the boot-vector overflow address then match the constants in R1, R7 and R9.

A behavioural model compares every output and the register selected on the software port on every cycle. The stimulus covers all sixteen kind codes and both values of every vector condition bit. It also covers a branch-target next PC, and shadow swaps that are allowed and blocked. Software writes arrive on the same edge as an exception, both to registers that the exception overrides and to registers it leaves alone.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [3:0] {
    KND_TLB_MOD     = 4'd0,
    KND_TLB_LD      = 4'd1,
    KND_TLB_ST      = 4'd2,
    KND_REFILL_LD   = 4'd3,
    KND_REFILL_ST   = 4'd4,
    KND_ADDR_LD     = 4'd5,
    KND_ADDR_ST     = 4'd6,
    KND_SYSCALL     = 4'd7,
    KND_BREAK       = 4'd8,
    KND_RESV        = 4'd9,
    KND_CP_UNUSABLE = 4'd10,
    KND_OVERFLOW    = 4'd11,
    KND_TRAP        = 4'd12,
    KND_INTR        = 4'd13
  } exc_kind_e;

  typedef enum logic [2:0] {
    RA_STATUS = 3'd0,
    RA_CAUSE  = 3'd1,
    RA_EPC    = 3'd2,
    RA_BADVA  = 3'd3,
    RA_SHADOW = 3'd4,
    RA_EBASE  = 3'd5
  } reg_addr_e;

  // Field positions that software decodes
  localparam int ST_EXL     = 1;
  localparam int ST_BEV     = 22;
  localparam int CA_CODE_LO = 2;
  localparam int CA_CODE_W  = 5;
  localparam int CA_IV      = 23;
  localparam int CA_CE_LO   = 28;
  localparam int CA_CE_W    = 2;
  localparam int CA_BD      = 31;
  localparam int SET_W      = 4;
  localparam int SS_CUR_LO  = 0;
  localparam int SS_PREV_LO = 6;
  localparam int SS_EXC_LO  = 12;

  function automatic logic [CA_CODE_W-1:0] kind_code(input logic [3:0] k);
    logic [CA_CODE_W-1:0] c;
    case (k)
      KND_TLB_MOD:                 c = 5'h01;
      KND_TLB_LD, KND_REFILL_LD:   c = 5'h02;
      KND_TLB_ST, KND_REFILL_ST:   c = 5'h03;
      KND_ADDR_LD:                 c = 5'h04;
      KND_ADDR_ST:                 c = 5'h05;
      KND_SYSCALL:                 c = 5'h08;
      KND_BREAK:                   c = 5'h09;
      KND_CP_UNUSABLE:             c = 5'h0B;
      KND_OVERFLOW:                c = 5'h0C;
      KND_TRAP:                    c = 5'h0D;
      default:                     c = 5'h0A;
    endcase
    return c;
  endfunction

  function automatic logic kind_loads_badva(input logic [3:0] k);
    return k <= KND_ADDR_ST;
  endfunction

  function automatic logic kind_is_refill(input logic [3:0] k);
    return (k == KND_REFILL_LD) || (k == KND_REFILL_ST);
  endfunction

endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] GEN_OFF     = 32'h0000_0180,
  parameter logic [XLEN-1:0] INT_OFF     = 32'h0000_0200,
  parameter logic [XLEN-1:0] OVF_BEV_VEC = 32'hBFC0_0200
) (
  input  logic [3:0]      kind,
  input  logic            exl,
  input  logic            bev,
  input  logic            iv,
  input  logic [XLEN-1:0] ebase,
  output logic [XLEN-1:0] handler
);

  logic [XLEN-1:0] gen_vec;
  logic [XLEN-1:0] int_vec;

  assign gen_vec = ebase + GEN_OFF;
  assign int_vec = ebase + INT_OFF;

  always_comb begin
    handler = gen_vec;
    if (kind_is_refill(kind)) begin
      handler = exl ? gen_vec : ebase;
    end else if (kind == KND_INTR) begin
      handler = iv ? int_vec : gen_vec;
    end else if (kind == KND_OVERFLOW) begin
      handler = bev ? OVF_BEV_VEC : gen_vec;
    end
  end

endmodule

// File: rtl/exc_pc_gen.sv
module exc_pc_gen #(
  parameter int              XLEN     = 32,
  parameter int              STEP     = 4,
  parameter logic [XLEN-1:0] RESET_PC = 32'hBFC0_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [XLEN-1:0] handler,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] npc_q,
  output logic [XLEN-1:0] nnpc_q,
  output logic            redirect_q
);

  localparam logic [XLEN-1:0] STEP1 = XLEN'(STEP);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= RESET_PC;
      npc_q      <= RESET_PC + STEP1;
      nnpc_q     <= RESET_PC + STEP2;
      redirect_q <= 1'b0;
    end else begin
      redirect_q <= load;
      if (load) begin
        pc_q   <= handler;
        npc_q  <= handler + STEP1;
        nnpc_q <= handler + STEP2;
      end
    end
  end

  p_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (redirect_q && pc_q == $past(handler)));

  p_redirect_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !redirect_q);

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              STEP       = 4,
  parameter logic [XLEN-1:0] STATUS_RST = 32'h2000_0000,
  parameter logic [XLEN-1:0] EBASE_RST  = 32'h8000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_valid,
  input  logic [3:0]      exc_kind,
  input  logic [XLEN-1:0] exc_pc,
  input  logic [XLEN-1:0] exc_npc,
  input  logic [XLEN-1:0] exc_badva,
  input  logic [1:0]      exc_cpnum,
  input  logic            sw_we,
  input  logic [2:0]      sw_addr,
  input  logic [XLEN-1:0] sw_wdata,
  output logic [XLEN-1:0] status_q,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] badva_q,
  output logic [XLEN-1:0] shadow_q,
  output logic [XLEN-1:0] ebase_q
);

  localparam logic [XLEN-1:0] STEP1 = XLEN'(STEP);

  logic            in_slot;
  logic            swap_ok;
  logic            take_badva;
  logic [XLEN-1:0] status_x, cause_x, epc_x, shadow_x;
  logic [XLEN-1:0] status_d, cause_d, epc_d, badva_d, shadow_d, ebase_d;
  logic [5:0]      sw_sel;

  assign in_slot    = exc_npc != (exc_pc + STEP1);
  assign swap_ok    = !status_q[ST_EXL] && !status_q[ST_BEV];
  assign take_badva = exc_valid && kind_loads_badva(exc_kind);

  // one-hot software select
  genvar gi;
  generate
    for (gi = 0; gi < 6; gi++) begin : g_sel
      assign sw_sel[gi] = sw_we && (sw_addr == 3'(gi));
    end
  endgenerate

  // exception images of each touched register
  always_comb begin
    status_x         = status_q;
    status_x[ST_EXL] = 1'b1;

    cause_x                             = cause_q;
    cause_x[CA_CODE_LO +: CA_CODE_W]    = kind_code(exc_kind);
    cause_x[CA_BD]                      = in_slot;
    cause_x[CA_CE_LO +: CA_CE_W]        = (exc_kind == KND_CP_UNUSABLE) ? exc_cpnum : 2'b00;

    epc_x = in_slot ? (exc_pc - STEP1) : exc_pc;

    shadow_x                         = shadow_q;
    shadow_x[SS_PREV_LO +: SET_W]    = shadow_q[SS_CUR_LO +: SET_W];
    shadow_x[SS_CUR_LO +: SET_W]     = shadow_q[SS_EXC_LO +: SET_W];
  end

  // merge: exception wins per register, software fills the rest
  always_comb begin
    status_d = status_q;
    cause_d  = cause_q;
    epc_d    = epc_q;
    badva_d  = badva_q;
    shadow_d = shadow_q;
    ebase_d  = ebase_q;

    if (exc_valid) begin
      status_d = status_x;
      cause_d  = cause_x;
      epc_d    = epc_x;
    end else begin
      if (sw_sel[RA_STATUS]) status_d = sw_wdata;
      if (sw_sel[RA_CAUSE])  cause_d  = sw_wdata;
      if (sw_sel[RA_EPC])    epc_d    = sw_wdata;
    end

    if (take_badva)              badva_d = exc_badva;
    else if (sw_sel[RA_BADVA])   badva_d = sw_wdata;

    if (exc_valid && swap_ok)    shadow_d = shadow_x;
    else if (sw_sel[RA_SHADOW])  shadow_d = sw_wdata;

    if (sw_sel[RA_EBASE])        ebase_d = sw_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
      cause_q  <= '0;
      epc_q    <= '0;
      badva_q  <= '0;
      shadow_q <= '0;
      ebase_q  <= EBASE_RST;
    end else begin
      status_q <= status_d;
      cause_q  <= cause_d;
      epc_q    <= epc_d;
      badva_q  <= badva_d;
      shadow_q <= shadow_d;
      ebase_q  <= ebase_d;
    end
  end

  p_exl_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> status_q[ST_EXL]);

  p_epc_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_npc == exc_pc + STEP1) |=> (epc_q == $past(exc_pc) && !cause_q[CA_BD]));

  p_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> cause_q[CA_CODE_LO +: CA_CODE_W] == kind_code($past(exc_kind)));

  p_ce_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_kind != KND_CP_UNUSABLE) |=> cause_q[CA_CE_LO +: CA_CE_W] == 2'b00);

  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && (status_q[ST_EXL] || status_q[ST_BEV]) && !(sw_we && sw_addr == RA_SHADOW))
    |=> shadow_q == $past(shadow_q));

  p_shadow_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !status_q[ST_EXL] && !status_q[ST_BEV])
    |=> (shadow_q[SS_CUR_LO +: SET_W] == $past(shadow_q[SS_EXC_LO +: SET_W]) &&
         shadow_q[SS_PREV_LO +: SET_W] == $past(shadow_q[SS_CUR_LO +: SET_W])));

  p_badva_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !kind_loads_badva(exc_kind) && !(sw_we && sw_addr == RA_BADVA))
    |=> badva_q == $past(badva_q));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              STEP        = 4,
  parameter logic [XLEN-1:0] RESET_PC    = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] STATUS_RST  = 32'h2000_0000,
  parameter logic [XLEN-1:0] EBASE_RST   = 32'h8000_0000,
  parameter logic [XLEN-1:0] GEN_OFF     = 32'h0000_0180,
  parameter logic [XLEN-1:0] INT_OFF     = 32'h0000_0200,
  parameter logic [XLEN-1:0] OVF_BEV_VEC = 32'hBFC0_0200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_valid,
  input  logic [3:0]      exc_kind,
  input  logic [XLEN-1:0] exc_pc,
  input  logic [XLEN-1:0] exc_npc,
  input  logic [XLEN-1:0] exc_badva,
  input  logic [1:0]      exc_cpnum,
  input  logic            sw_we,
  input  logic [2:0]      sw_addr,
  input  logic [XLEN-1:0] sw_wdata,
  output logic [XLEN-1:0] sw_rdata,
  output logic [XLEN-1:0] pc_out,
  output logic [XLEN-1:0] npc_out,
  output logic [XLEN-1:0] nnpc_out,
  output logic            redirect,
  output logic [3:0]      shadow_set
);

  logic [XLEN-1:0] status_q, cause_q, epc_q, badva_q, shadow_q, ebase_q;
  logic [XLEN-1:0] handler;

  exc_state_regs #(
    .XLEN(XLEN), .STEP(STEP), .STATUS_RST(STATUS_RST), .EBASE_RST(EBASE_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .exc_valid(exc_valid), .exc_kind(exc_kind), .exc_pc(exc_pc),
    .exc_npc(exc_npc), .exc_badva(exc_badva), .exc_cpnum(exc_cpnum),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .status_q(status_q), .cause_q(cause_q), .epc_q(epc_q),
    .badva_q(badva_q), .shadow_q(shadow_q), .ebase_q(ebase_q)
  );

  exc_vector_sel #(
    .XLEN(XLEN), .GEN_OFF(GEN_OFF), .INT_OFF(INT_OFF), .OVF_BEV_VEC(OVF_BEV_VEC)
  ) u_vec (
    .kind(exc_kind), .exl(status_q[ST_EXL]), .bev(status_q[ST_BEV]),
    .iv(cause_q[CA_IV]), .ebase(ebase_q), .handler(handler)
  );

  exc_pc_gen #(
    .XLEN(XLEN), .STEP(STEP), .RESET_PC(RESET_PC)
  ) u_pc (
    .clk(clk), .rst_n(rst_n), .load(exc_valid), .handler(handler),
    .pc_q(pc_out), .npc_q(npc_out), .nnpc_q(nnpc_out), .redirect_q(redirect)
  );

  always_comb begin
    case (sw_addr)
      RA_STATUS: sw_rdata = status_q;
      RA_CAUSE:  sw_rdata = cause_q;
      RA_EPC:    sw_rdata = epc_q;
      RA_BADVA:  sw_rdata = badva_q;
      RA_SHADOW: sw_rdata = shadow_q;
      RA_EBASE:  sw_rdata = ebase_q;
      default:   sw_rdata = '0;
    endcase
  end

  assign shadow_set = shadow_q[SS_CUR_LO +: SET_W];

  p_refill_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && kind_is_refill(exc_kind) && !status_q[ST_EXL]) |=> pc_out == $past(ebase_q));

  p_iv_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_kind == KND_INTR && cause_q[CA_IV]) |=> pc_out == $past(ebase_q) + INT_OFF);

  p_ovf_boot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_kind == KND_OVERFLOW && status_q[ST_BEV]) |=> pc_out == OVF_BEV_VEC);

endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_kind = 4'd0;
  logic [31:0] exc_pc = '0, exc_npc = '0, exc_badva = '0;
  logic [1:0]  exc_cpnum = '0;
  logic        sw_we = 1'b0;
  logic [2:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata, pc_out, npc_out, nnpc_out;
  logic        redirect;
  logic [3:0]  shadow_set;

  always #5 clk = ~clk;

  exc_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_kind(exc_kind),
    .exc_pc(exc_pc), .exc_npc(exc_npc), .exc_badva(exc_badva), .exc_cpnum(exc_cpnum),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .pc_out(pc_out), .npc_out(npc_out), .nnpc_out(nnpc_out),
    .redirect(redirect), .shadow_set(shadow_set)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R1";

  // behavioural reference state
  logic [31:0] m_regs [6];
  logic [31:0] m_pc, m_npc, m_nnpc;
  logic        m_red;

  function automatic int code_of(int k);
    case (k)
      0: return 1;  1: return 2;  2: return 3;  3: return 2;  4: return 3;
      5: return 4;  6: return 5;  7: return 8;  8: return 9;  10: return 11;
      11: return 12; 12: return 13; default: return 10;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_regs[0] = 32'h2000_0000; m_regs[1] = 0; m_regs[2] = 0;
      m_regs[3] = 0; m_regs[4] = 0; m_regs[5] = 32'h8000_0000;
      m_pc = 32'hBFC0_0000; m_npc = 32'hBFC0_0004; m_nnpc = 32'hBFC0_0008;
      m_red = 0;
    end else begin
      logic [31:0] n [6];
      logic        hit [6];
      for (int i = 0; i < 6; i++) begin n[i] = m_regs[i]; hit[i] = 0; end
      m_red = exc_valid;
      if (exc_valid) begin
        int          k;
        logic        exl, bev, slot;
        logic [31:0] h;
        k    = int'(exc_kind);
        exl  = m_regs[0][1];
        bev  = m_regs[0][22];
        slot = (exc_npc != exc_pc + 4);
        h    = m_regs[5] + 32'h180;
        if ((k == 3 || k == 4) && !exl) h = m_regs[5];
        if (k == 13 && m_regs[1][23]) h = m_regs[5] + 32'h200;
        if (k == 11 && bev) h = 32'hBFC0_0200;
        m_pc = h; m_npc = h + 4; m_nnpc = h + 8;
        n[0][1] = 1'b1; hit[0] = 1;
        n[1][6:2] = 5'(code_of(k)); n[1][31] = slot;
        n[1][29:28] = (k == 10) ? exc_cpnum : 2'b00; hit[1] = 1;
        n[2] = slot ? exc_pc - 4 : exc_pc; hit[2] = 1;
        if (k <= 6) begin n[3] = exc_badva; hit[3] = 1; end
        if (!exl && !bev) begin
          n[4][9:6] = m_regs[4][3:0]; n[4][3:0] = m_regs[4][15:12]; hit[4] = 1;
        end
      end
      if (sw_we && sw_addr < 6 && !hit[sw_addr]) n[sw_addr] = sw_wdata;
      for (int i = 0; i < 6; i++) m_regs[i] = n[i];
    end
  end

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", cur_tag, what, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("pc_out", pc_out, m_pc);
    chk("npc_out", npc_out, m_npc);
    chk("nnpc_out", nnpc_out, m_nnpc);
    chk("redirect", 32'(redirect), 32'(m_red));
    chk("shadow_set", 32'(shadow_set), 32'(m_regs[4][3:0]));
    chk("sw_rdata", sw_rdata, (sw_addr < 6) ? m_regs[sw_addr] : 32'h0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      exc_valid = 0; sw_we = 0; sw_addr = 3'(i % 8);
      tick();
    end
  endtask

  task automatic swr(int a, logic [31:0] d);
    sw_we = 1; sw_addr = 3'(a); sw_wdata = d; exc_valid = 0;
    tick();
    sw_we = 0;
  endtask

  task automatic exc_w(int k, logic [31:0] pc, logic [31:0] npc, logic [31:0] bva,
                       int cp, logic we, int a, logic [31:0] d);
    exc_valid = 1; exc_kind = 4'(k); exc_pc = pc; exc_npc = npc;
    exc_badva = bva; exc_cpnum = 2'(cp);
    sw_we = we; sw_addr = 3'(a); sw_wdata = d;
    tick();
    exc_valid = 0; sw_we = 0;
    idle(8);
  endtask

  task automatic exc(int k, logic [31:0] pc, logic [31:0] npc, logic [31:0] bva, int cp);
    exc_w(k, pc, npc, bva, cp, 1'b0, 0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    cur_tag = "R1"; idle(8);

    cur_tag = "R2";
    for (int k = 0; k < 16; k++) begin
      swr(0, 32'h0);
      exc(k, 32'h0040_0100 + 32'(k * 16), 32'h0040_0104 + 32'(k * 16), 32'hDEAD_0000 + 32'(k), 1);
    end

    cur_tag = "R3"; exc(8, 32'h0040_0200, 32'h0040_0300, 32'h0, 0);
    cur_tag = "R4"; exc(12, 32'h0040_0210, 32'h0040_0214, 32'h0, 0);

    cur_tag = "R5";
    swr(0, 32'h0); swr(4, 32'h0000_5002);
    cur_tag = "R7"; exc(3, 32'h0040_0400, 32'h0040_0404, 32'h1234_5000, 0);
    cur_tag = "R5"; exc(4, 32'h0040_0408, 32'h0040_0500, 32'h1234_6000, 0);

    cur_tag = "R8";
    swr(0, 32'h0); swr(1, 32'h0080_0000); exc(13, 32'h0040_0600, 32'h0040_0604, 32'h0, 0);
    swr(0, 32'h0); swr(1, 32'h0); exc(13, 32'h0040_0610, 32'h0040_0614, 32'h0, 0);

    cur_tag = "R9";
    swr(0, 32'h0040_0000); exc(11, 32'h0040_0700, 32'h0040_0704, 32'h0, 0);
    swr(0, 32'h0); exc(11, 32'h0040_0710, 32'h0040_0714, 32'h0, 0);

    cur_tag = "R6";
    exc(10, 32'h0040_0800, 32'h0040_0804, 32'h0, 3);
    exc(12, 32'h0040_0810, 32'h0040_0814, 32'h0, 3);

    cur_tag = "R11";
    swr(3, 32'hCAFE_0000);
    exc(7, 32'h0040_0900, 32'h0040_0904, 32'h7777_0000, 0);
    exc(6, 32'h0040_0910, 32'h0040_0914, 32'h7777_1111, 0);

    cur_tag = "R10";
    exc(0, 32'h0040_0A00, 32'h0040_0A04, 32'h5555_0000, 0);

    cur_tag = "R12";
    swr(7, 32'hFFFF_FFFF); idle(8);
    exc_w(7, 32'h0040_0B00, 32'h0040_0B04, 32'h0, 0, 1'b1, 2, 32'h1111_1111);
    exc_w(7, 32'h0040_0B10, 32'h0040_0B14, 32'h0, 0, 1'b1, 5, 32'h9000_0000);
    exc_w(7, 32'h0040_0B20, 32'h0040_0B24, 32'h0, 0, 1'b1, 3, 32'h3333_0000);
    exc(9, 32'h0040_0B30, 32'h0040_0B34, 32'h0, 0);
    swr(0, 32'h0);
    exc_w(8, 32'h0040_0B40, 32'h0040_0B44, 32'h0, 0, 1'b1, 4, 32'h0000_7000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule